// File: doc/BRIEF.md
# Two-Section Decade Ripple Counter

The block is a four-bit counter split into two sections that share nothing but their clear and preset controls. The low section is a single toggle stage. Its own clock input advances it, and it drives output bit 0. The high section counts modulo five on a separate clock input and drives output bits 3 to 1. Both sections advance on the falling edge of their clock.

The sections are chained outside the block. With bit 0 wired to the high-section clock, the outputs count in BCD from 0 to 9. With bit 3 wired to the low-section clock and counting driven on the high-section clock, the outputs follow a bi-quinary sequence: five even values, then five odd values.

Two AND-gated control pairs act asynchronously and hold the outputs while asserted. One pair clears the count. The other forces it to nine. A chip-level active-low reset overrides both pairs.

Top module: `dcnt_decade`

## Requirements
- R1: With no clear, preset or reset active, q_o[0] inverts on every falling edge of clk0_i, and q_o[3:1] is unaffected by clk0_i.
- R2: With no clear, preset or reset active, q_o[3:1] read as an unsigned number steps 0,1,2,3,4,0 on each falling edge of clk1_i, and q_o[0] is unaffected by clk1_i.
- R3: q_o[3] is 1 exactly when q_o[3:1] holds 4; its fall on the wrap from 4 to 0 is the carry of the high section.
- R4: While clr_a_i and clr_b_i are both 1 and the preset pair is not both 1, q_o is 0 at once and stays 0 across clock edges; with only one of the two high, the clear has no effect.
- R5: While set_a_i and set_b_i are both 1, q_o is 4'b1001 (nine) at once and held, even when the clear pair is also active; with only one of the two high, the preset has no effect.
- R6: While rst_ni is 0, q_o is 0, overriding both the preset and the clear pairs.
- R7: With q_o[0] fed to clk1_i, falling edges on clk0_i give q_o = k mod 10 after k edges, wrapping from 9 to 0.
- R8: With q_o[3] fed to clk0_i, falling edges on clk1_i give q_o = 2*(k mod 5) + ((k/5) mod 2) after k edges: 0,2,4,6,8,1,3,5,7,9,0.
- R9: After the clear, preset and reset are released, the count holds until the next falling clock edge, which advances it from the held value. In either chained order, nine goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset, clears all bits |
| clk0_i | input | 1 | Falling-edge clock of the divide-by-two section |
| clk1_i | input | 1 | Falling-edge clock of the divide-by-five section |
| clr_a_i | input | 1 | Clear gate input A |
| clr_b_i | input | 1 | Clear gate input B |
| set_a_i | input | 1 | Preset-to-nine gate input A |
| set_b_i | input | 1 | Preset-to-nine gate input B |
| q_o | output | 4 | Count: bit 0 from the low section, bits 3:1 from the high section |

## Verification
The properties are sampled on the falling edges of the section clocks. They assume that the asynchronous controls never change in the same time step as a falling clock edge, so the sampled control level has already acted on the flops.

The bench changes every control on an offset delay away from the clock pulses. In chained mode the clock lines are derived from the outputs, so changing the chaining could itself produce an edge. Before every change of chaining, the bench clears the counter and holds its driven clock lines low, so no stray edge appears.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int unsigned HI_MOD_DEF = 5;
  localparam int unsigned LO_MOD     = 2;
endpackage

// File: rtl/dcnt_gate.sv
module dcnt_gate (
  input  logic rst_ni,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic set_a_i,
  input  logic set_b_i,
  output logic clr_o,
  output logic set_o
);
  logic clr_req, set_req;

  always_comb begin
    clr_req = clr_a_i & clr_b_i;
    set_req = set_a_i & set_b_i;
    // reset > preset > clear; clr_o rises when preset drops under a held clear
    set_o   = rst_ni & set_req;
    clr_o   = ~rst_ni | (clr_req & ~set_req);
  end
endmodule

// File: rtl/dcnt_div2.sv
module dcnt_div2 (
  input  logic clk_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  logic q_q;

  always_ff @(negedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
    else            q_q <= ~q_q;
  end

  assign q_o = q_q;

  p_preset_hold_r5: assert property (@(negedge clk_i) disable iff (clr_i)
    set_i |-> q_q == 1'b1);
  p_clear_hold_r4: assert property (@(negedge clk_i) disable iff (set_i)
    clr_i |-> q_q == 1'b0);
endmodule

// File: rtl/dcnt_divn.sv
module dcnt_divn #(
  parameter int unsigned MOD = 5,
  localparam int unsigned W = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic         set_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (cnt_q == TOP) cnt_nx = '0;
    else              cnt_nx = cnt_q + W'(1);
  end

  always_ff @(negedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      cnt_q <= '0;
    else if (set_i) cnt_q <= TOP;
    else            cnt_q <= cnt_nx;
  end

  assign cnt_o = cnt_q;

  p_in_range_r2: assert property (@(negedge clk_i) disable iff (clr_i || set_i)
    cnt_q <= TOP);
  p_preset_hold_r5: assert property (@(negedge clk_i) disable iff (clr_i)
    set_i |-> cnt_q == TOP);
  p_clear_hold_r4: assert property (@(negedge clk_i) disable iff (set_i)
    clr_i |-> cnt_q == '0);
endmodule

// File: rtl/dcnt_decade.sv
module dcnt_decade #(
  parameter int unsigned HI_MOD = dcnt_pkg::HI_MOD_DEF
) (
  input  logic                    rst_ni,
  input  logic                    clk0_i,
  input  logic                    clk1_i,
  input  logic                    clr_a_i,
  input  logic                    clr_b_i,
  input  logic                    set_a_i,
  input  logic                    set_b_i,
  output logic [$clog2(HI_MOD):0] q_o
);
  localparam int unsigned HI_W = $clog2(HI_MOD);

  logic            clr_eff, set_eff;
  logic            lo_q;
  logic [HI_W-1:0] hi_q;

  dcnt_gate u_gate (
    .rst_ni  (rst_ni),
    .clr_a_i (clr_a_i),
    .clr_b_i (clr_b_i),
    .set_a_i (set_a_i),
    .set_b_i (set_b_i),
    .clr_o   (clr_eff),
    .set_o   (set_eff)
  );

  dcnt_div2 u_lo (
    .clk_i (clk0_i),
    .clr_i (clr_eff),
    .set_i (set_eff),
    .q_o   (lo_q)
  );

  dcnt_divn #(.MOD(HI_MOD)) u_hi (
    .clk_i (clk1_i),
    .clr_i (clr_eff),
    .set_i (set_eff),
    .cnt_o (hi_q)
  );

  assign q_o = {hi_q, lo_q};

  p_reset_zero_r6: assert property (@(negedge clk1_i)
    !rst_ni |-> q_o == '0);

  generate
    if (HI_MOD == 5) begin : g_carry_chk
      p_top_bit_r3: assert property (@(negedge clk1_i) disable iff (!rst_ni)
        q_o[HI_W] |-> q_o[HI_W-1:1] == '0);
    end
  endgenerate
endmodule

// File: tb/dcnt_decade_bench.sv
module dcnt_decade_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic       rst_ni;
  logic       c0_drv, c1_drv;
  logic       clr_a, clr_b, set_a, set_b;
  logic [1:0] mode; // 0 independent, 1 BCD, 2 bi-quinary
  logic       clk0, clk1;
  logic [3:0] q;
  int         n_chk, n_fail;

  assign clk0 = (mode == 2'd2) ? q[3] : c0_drv;
  assign clk1 = (mode == 2'd1) ? q[0] : c1_drv;

  dcnt_decade u_dcnt_decade (
    .rst_ni  (rst_ni),
    .clk0_i  (clk0),
    .clk1_i  (clk1),
    .clr_a_i (clr_a),
    .clr_b_i (clr_b),
    .set_a_i (set_a),
    .set_b_i (set_b),
    .q_o     (q)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic pulse0();
    c0_drv = 1'b1; #(HALF);
    c0_drv = 1'b0; #(HALF);
  endtask

  task automatic pulse1();
    c1_drv = 1'b1; #(HALF);
    c1_drv = 1'b0; #(HALF);
  endtask

  task automatic clear_to(input logic [1:0] m);
    #1 clr_a = 1'b1; clr_b = 1'b1;
    #1 mode = m;
    #1 clr_a = 1'b0; clr_b = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    n_chk = 0; n_fail = 0;
    mode = 2'd0; c0_drv = 0; c1_drv = 0;
    clr_a = 0; clr_b = 0; set_a = 0; set_b = 0;
    rst_ni = 1'b0;
    #(CLK_PERIOD);
    chk("R6 reset", q, 4'd0);
    rst_ni = 1'b1; #1;

    // R1: low section alone
    for (int k = 1; k <= 4; k++) begin
      pulse0();
      chk("R1 toggle", q, {3'b000, 1'(k % 2)});
    end
    // R2/R3: high section alone, bit 0 set first
    pulse0();
    for (int k = 1; k <= 11; k++) begin
      pulse1();
      chk("R2 mod5", q, {3'(k % 5), 1'b1});
      chk("R3 top bit", {3'b000, q[3]}, {3'b000, 1'((k % 5) == 4)});
    end
    // R1: clk0 leaves the high bits alone
    prev = q;
    pulse0();
    chk("R1 high untouched", {1'b0, q[3:1]}, {1'b0, prev[3:1]});

    // R4: single clear input has no effect
    #1 clr_a = 1'b1; #1;
    chk("R4 single clear", q, prev ^ 4'b0001);
    clr_a = 1'b0; #1;
    #1 clr_b = 1'b1; #1;
    pulse0();
    chk("R4 single clear count", q, prev);
    clr_b = 1'b0; #1;
    // R4: both high clears and holds
    #1 clr_a = 1'b1; clr_b = 1'b1; #1;
    chk("R4 clear", q, 4'd0);
    pulse0(); pulse1();
    chk("R4 clear held", q, 4'd0);
    #1 mode = 2'd1;
    #1 clr_a = 1'b0; clr_b = 1'b0; #1;

    // R7: BCD over 25 edges
    for (int k = 1; k <= 25; k++) begin
      pulse0();
      chk("R7 bcd", q, 4'(k % 10));
    end

    // R5: single preset input has no effect
    clear_to(2'd1);
    #1 set_a = 1'b1; #1;
    chk("R5 single preset", q, 4'd0);
    set_a = 1'b0; #1 set_b = 1'b1; #1;
    chk("R5 single preset b", q, 4'd0);
    set_b = 1'b0; #1;
    // R5: preset to nine, priority over clear
    #1 set_a = 1'b1; set_b = 1'b1; #1;
    chk("R5 preset", q, 4'd9);
    #1 clr_a = 1'b1; clr_b = 1'b1; #1;
    chk("R5 preset over clear", q, 4'd9);
    pulse0();
    chk("R5 preset held", q, 4'd9);
    // R4: dropping preset under a held clear clears
    #1 set_a = 1'b0; #1;
    chk("R4 clear after preset", q, 4'd0);
    #1 clr_a = 1'b0; clr_b = 1'b0;
    #1 set_a = 1'b1; #1;
    chk("R5 preset again", q, 4'd9);
    // R6: reset overrides preset
    #1 rst_ni = 1'b0; #1;
    chk("R6 over preset", q, 4'd0);
    #1 rst_ni = 1'b1; #1;
    chk("R5 preset after reset", q, 4'd9);
    // R9: release then resume at next edge, BCD 9 -> 0
    #1 set_a = 1'b0; set_b = 1'b0; #(HALF);
    chk("R9 hold after release", q, 4'd9);
    pulse0();
    chk("R9 bcd wrap", q, 4'd0);
    pulse0();
    chk("R9 bcd next", q, 4'd1);

    // R8: bi-quinary over 25 edges
    clear_to(2'd2);
    for (int k = 1; k <= 25; k++) begin
      pulse1();
      chk("R8 biquinary", q, 4'(2 * (k % 5) + ((k / 5) % 2)));
    end
    // R9: preset then release in bi-quinary order
    #1 set_a = 1'b1; set_b = 1'b1; #1;
    chk("R5 preset biq", q, 4'd9);
    #1 set_a = 1'b0; set_b = 1'b0; #1;
    pulse1();
    chk("R9 biq wrap", q, 4'd0);
    pulse1();
    chk("R9 biq next", q, 4'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule